// File: doc/BRIEF.md
# Cascade Start Synchronizer

This block lines up a group of identical physical-layer devices that share one point-to-point link. Every device in the group carries one copy. Each copy has a one-bit cascade enable that comes from its mode register, and a one-cycle pulse from its receiver whenever a JK start pair is seen. The copies share two signals. The first is a wired-AND ready line: each copy pulls it low while it is not ready and lets it float once it is ready. The second is a common start input, which goes high only when every copy has let the line go.

A copy becomes ready when its cascade enable is one and it has seen a JK pair. It holds that condition until the enable is removed or reset is applied. The shared start input is treated as asynchronous. It passes through a chain of synchronizer flops, and its rising edge produces a single aligned-start pulse in every ready copy. All devices then begin aligned operation on the same cycle.

Top module: `cascade_sync`

## Requirements
- R1: After reset, `ready_pull` is 1 (the copy pulls the shared line low) and `align_start` is 0.
- R2: A `jk_pulse` sampled while `mode_en` is 1 sets `ready_pull` to 0 from the next clock edge onwards.
- R3: A `jk_pulse` sampled while `mode_en` is 0 is ignored. `ready_pull` stays 1, and it remains 1 after `mode_en` is later set, until a new JK pulse arrives.
- R4: Once released, `ready_pull` stays 0 for as long as `mode_en` stays 1, even after `jk_pulse` returns to 0.
- R5: A `mode_en` of 0 at a clock edge sets `ready_pull` back to 1 after that edge. This also applies after start has occurred.
- R6: A rising edge of `start_in` that is stable before clock edge k makes `align_start` 1 for exactly one cycle, after edge k+SYNC_STAGES-1. With the default of 2 this is the cycle after edge k+1. The copy must be released and `mode_en` must be 1 during that cycle.
- R7: No `align_start` pulse appears if the synchronized start edge arrives while the copy is not released.
- R8: When `mode_en` falls in the same cycle as a JK pulse or a synchronized start edge, the fall wins. The copy is not released and no pulse is produced.
- R9: While `start_in` stays high, no further `align_start` pulse appears. Only a new rising edge yields a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mode_en | input | 1 | Cascade enable bit from the mode register |
| jk_pulse | input | 1 | One-cycle pulse: a JK start pair was received |
| start_in | input | 1 | Shared start input (asynchronous) |
| ready_pull | output | 1 | 1 = pull the shared ready line low; 0 = let it float |
| align_start | output | 1 | One-cycle aligned-start pulse |

## Verification
Two events can coincide with the removal of cascade enable: the latching of a JK pulse, and the detection of a synchronized start edge. The vector table provokes both cases. In one case `mode_en` drops on the very edge where the start edge reaches the last synchronizer stage. In the other, a JK pulse arrives in a cycle where `mode_en` is already low. In both cases the bench expects `ready_pull` to be 1 and `align_start` to be 0. A second phase connects three copies through a modelled pull-up line and checks that the pulse appears in every copy at the same time, and only after the last copy has let go of the line.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
    typedef enum logic {
        RDY_HOLD = 1'b0,
        RDY_FREE = 1'b1
    } rdy_state_e;

    typedef struct packed {
        rdy_state_e st;
    } latch_reg_t;
endpackage

// File: rtl/cascade_ready_latch.sv
module cascade_ready_latch
    import cascade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic jk_pulse,
    output logic released,
    output logic ready_pull
);
    latch_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!mode_en)
            r_d.st = RDY_HOLD;
        else if (jk_pulse)
            r_d.st = RDY_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RDY_HOLD};
        else        r_q <= r_d;
    end

    assign released   = (r_q.st == RDY_FREE);
    assign ready_pull = ~released;

    // R2
    jk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && jk_pulse) |=> !ready_pull);
    // R4
    hold_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && !ready_pull) |=> !ready_pull);
    // R5
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> ready_pull);
endmodule

// File: rtl/cascade_start_sync.sv
module cascade_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_raw,
    output logic start_rise
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } sync_reg_t;

    sync_reg_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[DEPTH-2:0], start_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_rise = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> !start_rise);
endmodule

// File: rtl/cascade_sync.sv
module cascade_sync
    import cascade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic jk_pulse,
    input  logic start_in,
    output logic ready_pull,
    output logic align_start
);
    logic released;
    logic start_rise;

    cascade_ready_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .jk_pulse   (jk_pulse),
        .released   (released),
        .ready_pull (ready_pull)
    );

    cascade_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_raw  (start_in),
        .start_rise (start_rise)
    );

    assign align_start = start_rise & released & mode_en;

    // R7
    pulse_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_start |-> !ready_pull);
    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_start |=> !align_start);
    // R8
    pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> !align_start);
endmodule

// File: tb/cascade_sync_test.sv
module cascade_sync_test;
    localparam int N_DEV = 3;
    localparam int NVEC  = 20;
    // fields: {mode, jk, start, exp_pull, exp_pulse}
    localparam logic [4:0] VEC [0:NVEC-1] = '{
        5'b000_1_0, 5'b010_1_0, 5'b100_1_0, 5'b110_0_0, 5'b100_0_0,
        5'b101_0_0, 5'b101_0_1, 5'b101_0_0, 5'b101_0_0, 5'b100_0_0,
        5'b100_0_0, 5'b000_1_0, 5'b011_1_0, 5'b101_1_0, 5'b110_0_0,
        5'b100_0_0, 5'b101_0_0, 5'b001_1_0, 5'b111_0_0, 5'b010_1_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_DEV-1:0] mode = '0;
    logic [N_DEV-1:0] jk = '0;
    logic [N_DEV-1:0] pull;
    logic [N_DEV-1:0] pulse;
    logic tbl_start = 1'b0;
    logic use_tbl = 1'b1;
    logic line;
    logic start_in;
    int applied = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign line     = ~|pull;                 // pull-up, any copy pulls low
    assign start_in = use_tbl ? tbl_start : line;

    cascade_sync uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode[0]), .jk_pulse(jk[0]),
        .start_in(start_in), .ready_pull(pull[0]), .align_start(pulse[0])
    );

    for (genvar g = 1; g < N_DEV; g++) begin : g_peer
        cascade_sync peer (
            .clk(clk), .rst_n(rst_n), .mode_en(mode[g]), .jk_pulse(jk[g]),
            .start_in(start_in), .ready_pull(pull[g]), .align_start(pulse[g])
        );
    end

    task automatic chk(input string req, input logic act, input logic exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 5000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        int cnt [N_DEV];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 pull", pull[0], 1'b1);
        chk("R1 pulse", pulse[0], 1'b0);

        // table phase: R2 R3 R4 R5 R6 R7 R8 R9 on uut
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            mode[0]   = VEC[i][4];
            jk[0]     = VEC[i][3];
            tbl_start = VEC[i][2];
            step();
            chk($sformatf("vec%0d pull R2_R3_R4_R5_R8", i), pull[0], VEC[i][1]);
            chk($sformatf("vec%0d pulse R6_R7_R8_R9", i), pulse[0], VEC[i][0]);
        end

        // reset while released: R1
        @(negedge clk);
        mode[0] = 1'b1; jk[0] = 1'b1;
        @(negedge clk);
        jk[0] = 1'b0;
        chk("R2 pre-reset", pull[0], 1'b0);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid-run", pull[0], 1'b1);

        // wired-AND phase
        @(negedge clk);
        rst_n = 1'b1; use_tbl = 1'b0; mode = '1;
        for (int o = 0; o < N_DEV; o++) begin
            int d;
            d = (o + 2) % N_DEV;
            @(negedge clk);
            jk[d] = 1'b1;
            if (o < N_DEV - 1) begin
                for (int c = 0; c < 5; c++) begin
                    step();
                    jk[d] = 1'b0;
                    chk("R7 line held low", line, 1'b0);
                    chk("R7 no early pulse", |pulse, 1'b0);
                end
            end else begin
                step();
                jk[d] = 1'b0;
                chk("R2 line free", line, 1'b1);
                step();
                chk("R6 not yet", |pulse, 1'b0);
                step();
                chk("R6 aligned pulse", &pulse, 1'b1);
            end
        end
        for (int k = 0; k < N_DEV; k++) cnt[k] = 0;
        for (int c = 0; c < 8; c++) begin
            step();
            for (int k = 0; k < N_DEV; k++) if (pulse[k]) cnt[k]++;
        end
        for (int k = 0; k < N_DEV; k++) chk("R9 single pulse", cnt[k] == 0, 1'b1);

        // mode cleared after start: R5
        @(negedge clk);
        mode[0] = 1'b0;
        step();
        chk("R5 pull after start", pull[0], 1'b1);
        chk("R5 line low", line, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule